// File: doc/BRIEF.md
# I/Q Sample Input Conditioner

This block is the first stage of a demodulator datapath. Every master clock cycle it can accept one pair of 6-bit in-phase and quadrature samples. The master clock runs at twice the symbol rate, so two sample pairs arrive per symbol. Each sample is normalised to signed two's complement. The incoming coding can be either two's complement already or offset binary, where a code of mid-scale means zero. The quadrature sample can then be negated to reverse the rotation convention. This is the same as swapping I and Q, or mirroring the spectrum. Negating the most negative code saturates rather than wrapping.

The conditioned pair is registered and sent out with one of two strobes. One strobe feeds the pulse-shaping filter and the other feeds the recovery section directly, so the filter can be bypassed. The data bus is shared by both strobes.

Separately, a free-running divider derived from the same master clock produces a one-cycle enable pulse once every 60 cycles for use elsewhere in the system.

Top module: `iq_input_cond`

## Requirements
- R1: While reset is asserted, both strobes and the divide tick are low and both output samples are zero.
- R2: With `fmt_offset` low, an input code is taken as two's complement and appears unchanged on the I output.
- R3: With `fmt_offset` high, each input code is read as offset binary and converted by inverting bit 5: code 0 gives -32, code 32 gives 0, code 63 gives +31.
- R4: With `q_invert` high, the Q output is the arithmetic negative of the converted Q sample, and the I output is unaffected.
- R5: Negating a converted Q value of -32 gives +31, so the Q output is never -32 while `q_invert` is high.
- R6: A pair accepted with `in_valid` appears on the outputs exactly one clock later. It comes with `to_filter_valid` if `bypass` was low at acceptance, or with `to_recov_valid` if `bypass` was high. The two strobes are never high together.
- R7: In a cycle without `in_valid`, no strobe is raised in the following cycle and both output samples keep their values.
- R8: After reset is released, `tick_div60` is high for one cycle after the 59th rising edge, and then once every 60 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the symbol rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample pair present this cycle |
| in_i | input | 6 | Raw in-phase sample |
| in_q | input | 6 | Raw quadrature sample |
| fmt_offset | input | 1 | 1: inputs are offset binary; 0: two's complement |
| q_invert | input | 1 | 1: negate the quadrature sample |
| bypass | input | 1 | 1: route to the recovery section, skipping the filter |
| to_filter_valid | output | 1 | Output pair is meant for the shaping filter |
| to_recov_valid | output | 1 | Output pair goes straight to recovery |
| out_i | output | 6 | Conditioned in-phase sample, signed |
| out_q | output | 6 | Conditioned quadrature sample, signed |
| tick_div60 | output | 1 | One-cycle enable every 60 master clocks |

## Verification
If the format or negate logic is wrong, the bad value shows on the sample outputs one cycle after the pair is accepted. The scoreboard catches it there, including at the -32, 0 and +31 edges. If the routing or the strobes are wrong, a strobe is missing, doubled or late at that same cycle. If the data registers drift while idle, the change is visible in the next idle cycle. If the divider count is wrong, the tick moves away from the 59th edge after reset, or the 60-cycle spacing breaks at the next period.

// File: rtl/iqc_pkg.sv
package iqc_pkg;
  localparam int IQC_LANES = 2;
  localparam int LANE_I    = 0;
  localparam int LANE_Q    = 1;

  typedef enum logic {
    ROUTE_FILTER = 1'b0,
    ROUTE_RECOV  = 1'b1
  } route_e;
endpackage

// File: rtl/iqc_format.sv
module iqc_format #(
  parameter int W = 6
) (
  input  logic [W-1:0]        raw,
  input  logic                offset_mode,
  output logic signed [W-1:0] conv
);
  always_comb begin
    conv = raw;
    if (offset_mode) begin
      conv[W-1] = ~raw[W-1];
    end
  end
endmodule

// File: rtl/iqc_negate.sv
module iqc_negate #(
  parameter int W = 6
) (
  input  logic signed [W-1:0] d_in,
  input  logic                en,
  output logic signed [W-1:0] d_out
);
  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (!en) begin
      d_out = d_in;
    end else if (d_in == MOST_NEG) begin
      d_out = MOST_POS;
    end else begin
      d_out = -d_in;
    end
  end

  // R5: a negated sample never lands on the most negative code
  always_comb begin
    if (en) begin
      a_r5_no_most_neg: assert (d_out != MOST_NEG);
    end
  end
endmodule

// File: rtl/iqc_rate_div.sv
module iqc_rate_div #(
  parameter int DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = (cnt_q == LAST);

  // R8: counter stays in range and the tick is a single-cycle pulse
  a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/iq_input_cond.sv
module iq_input_cond #(
  parameter int W   = 6,
  parameter int DIV = 60
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [W-1:0]        in_i,
  input  logic [W-1:0]        in_q,
  input  logic                fmt_offset,
  input  logic                q_invert,
  input  logic                bypass,
  output logic                to_filter_valid,
  output logic                to_recov_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q,
  output logic                tick_div60
);
  import iqc_pkg::*;

  logic [W-1:0]        raw_lane  [IQC_LANES];
  logic signed [W-1:0] conv_lane [IQC_LANES];
  logic signed [W-1:0] cond_lane [IQC_LANES];

  assign raw_lane[LANE_I] = in_i;
  assign raw_lane[LANE_Q] = in_q;

  for (genvar g = 0; g < IQC_LANES; g++) begin : g_lane
    iqc_format #(.W(W)) u_fmt (
      .raw         (raw_lane[g]),
      .offset_mode (fmt_offset),
      .conv        (conv_lane[g])
    );
    if (g == LANE_Q) begin : g_neg
      iqc_negate #(.W(W)) u_neg (
        .d_in  (conv_lane[g]),
        .en    (q_invert),
        .d_out (cond_lane[g])
      );
    end else begin : g_pass
      assign cond_lane[g] = conv_lane[g];
    end
  end

  // next-state for the output stage
  route_e              route;
  logic                flt_v_d, rec_v_d;
  logic signed [W-1:0] i_d, q_d;

  always_comb begin
    route   = bypass ? ROUTE_RECOV : ROUTE_FILTER;
    flt_v_d = in_valid && (route == ROUTE_FILTER);
    rec_v_d = in_valid && (route == ROUTE_RECOV);
    i_d     = out_i;
    q_d     = out_q;
    if (in_valid) begin
      i_d = cond_lane[LANE_I];
      q_d = cond_lane[LANE_Q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_filter_valid <= 1'b0;
      to_recov_valid  <= 1'b0;
      out_i           <= '0;
      out_q           <= '0;
    end else begin
      to_filter_valid <= flt_v_d;
      to_recov_valid  <= rec_v_d;
      out_i           <= i_d;
      out_q           <= q_d;
    end
  end

  iqc_rate_div #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_div60)
  );

  // R6: one-cycle latency and exclusive routing
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (to_filter_valid || to_recov_valid));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(to_filter_valid && to_recov_valid));
  a_r6_route_recov: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bypass) |=> to_recov_valid);
  // R7: idle cycles raise no strobe and keep the data
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!to_filter_valid && !to_recov_valid
                   && $stable(out_i) && $stable(out_q)));
endmodule

// File: tb/iq_input_cond_bench.sv
`timescale 1ns/1ps
module iq_input_cond_bench;
  localparam int W = 6;
  localparam int DIV = 60;

  typedef struct {
    logic signed [W-1:0] i;
    logic signed [W-1:0] q;
    logic                byp;
    int                  due;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_i = '0;
  logic [W-1:0] in_q = '0;
  logic fmt_offset = 1'b0;
  logic q_invert = 1'b0;
  logic bypass = 1'b0;
  logic to_filter_valid, to_recov_valid, tick_div60;
  logic signed [W-1:0] out_i, out_q;

  int checks = 0;
  int failures = 0;
  int edges = 0;
  bit finished = 0;
  exp_t sb[$];
  logic signed [W-1:0] last_i = '0, last_q = '0;

  iq_input_cond #(.W(W), .DIV(DIV)) u_iq_input_cond (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .fmt_offset(fmt_offset), .q_invert(q_invert), .bypass(bypass),
    .to_filter_valid(to_filter_valid), .to_recov_valid(to_recov_valid),
    .out_i(out_i), .out_q(out_q), .tick_div60(tick_div60)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [W-1:0] model(input logic [W-1:0] x,
                                                 input bit off, input bit neg);
    logic signed [W-1:0] v;
    v = off ? (x ^ 6'h20) : x;
    if (neg) v = (v == -6'sd32) ? 6'sd31 : -v;
    return v;
  endfunction

  // driver: one pair per call, optional idle cycles after it
  task automatic drive(input logic [W-1:0] i, input logic [W-1:0] q,
                       input bit off, input bit neg, input bit byp, input int gap);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_i = i; in_q = q;
    fmt_offset = off; q_invert = neg; bypass = byp;
    e.i = model(i, off, 1'b0);
    e.q = model(q, off, neg);
    e.byp = byp;
    e.due = edges + 1;
    sb.push_back(e);
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      fmt_offset = ~off; q_invert = ~neg; bypass = ~byp;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(tick_div60 == ((edges % DIV) == DIV - 1), "R8 tick", tick_div60,
            (edges % DIV) == DIV - 1);
      check(!(to_filter_valid && to_recov_valid), "R6 exclusive", 1, 0);
      if (to_filter_valid || to_recov_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7 unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(edges == e.due, "R6 latency", edges, e.due);
          check(to_recov_valid == e.byp, "R6 route", to_recov_valid, e.byp);
          check(out_i == e.i, "R2/R3 I sample", out_i, e.i);
          check(out_q == e.q, "R3/R4/R5 Q sample", out_q, e.q);
        end
      end else begin
        check(out_i == last_i && out_q == last_q, "R7 hold", out_i, last_i);
      end
      last_i = out_i;
      last_q = out_q;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!to_filter_valid && !to_recov_valid && !tick_div60, "R1 strobes", 1, 0);
    check(out_i == 0 && out_q == 0, "R1 data", out_i, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    // R2 two's complement pass-through
    drive(6'h05, 6'h3B, 0, 0, 0, 0);
    drive(6'h20, 6'h1F, 0, 0, 0, 1);
    // R3 offset binary edges
    drive(6'h00, 6'h20, 1, 0, 0, 0);
    drive(6'h3F, 6'h21, 1, 0, 1, 2);
    // R4 negate, I unaffected
    drive(6'h07, 6'h07, 0, 1, 0, 0);
    drive(6'h3A, 6'h3A, 0, 1, 1, 0);
    // R5 saturation in both formats
    drive(6'h20, 6'h20, 0, 1, 0, 1);
    drive(6'h00, 6'h00, 1, 1, 1, 0);
    drive(6'h1F, 6'h1F, 0, 1, 0, 3);
    // R6 routing alternating back to back
    for (int n = 0; n < 20; n++)
      drive(W'(n * 5), W'(n * 11 + 3), n[0], n[1], n[2], n % 3);
    @(negedge clk);
    in_valid = 1'b0;
    // R8 run long enough for several divide periods
    repeat (200) @(negedge clk);
    check(sb.size() == 0, "R6 missing output", sb.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule